// File: doc/BRIEF.md
# Byte-Pair to 16-bit Bus Bridge

This bridge sits between an 8-bit host port and a 16-bit parallel device bus. The host talks to it one byte at a time, and each host transfer starts on a rising edge of the host strobe. The bridge pairs those bytes into device words. A write word is sent on the device bus only after both of its bytes have arrived. A read word is fetched from the device in one cycle and handed back to the host as two bytes.

The same strobe can also load an address byte. Its upper nibble selects the module and its lower nibble selects the register, and both nibbles drive the device address lines. A single byte-phase toggle keeps track of whether the next data byte is the low half or the high half of a word. Loading an address always sends the toggle back to the low half.

Toward the device, the bridge drives active-low read, write and enable strobes. It also drives a bus-drive indicator for an external transceiver. The bridge releases the 16-bit data lines whenever it is not writing.

Top module: `bytepair_bridge`

## Requirements
- R1: While reset is applied and after it is released, dev_rd_n, dev_wr_n and dev_en_n are 1, dev_oe is 0, host_rdata is 0, both address outputs are 0, and the byte phase is low.
- R2: A rising host_stb with host_ld=1 loads dev_madr from host_wdata[7:4] and dev_radr from host_wdata[3:0]. The new values appear on the clock after the edge is seen.
- R3: The first data write strobe of a pair captures host_wdata as the low byte. It causes no device strobe and does not drive the bus.
- R4: The second data write strobe captures the high byte. dev_wr_n then goes low for WR_PULSE clocks, starting two clocks after the edge is seen. During that pulse, dev_data carries {high, low}.
- R5: dev_oe is 1 for exactly the clock before the write pulse, the clocks of the pulse, and the clock after it. At all other times it is 0 and dev_data is released.
- R6: dev_en_n is 0 exactly when dev_rd_n or dev_wr_n is 0. The two strobes are never low together.
- R7: The first read request of a pair drives dev_rd_n low for RD_PULSE clocks, and the bridge does not drive the bus during that time. The device word is sampled on the last clock of the pulse, and its bits [7:0] then appear on host_rdata.
- R8: The second read request of a pair puts bits [15:8] of the sampled word on host_rdata. It issues no device strobe.
- R9: A rising host_stb that arrives while a device cycle is in progress is ignored entirely. It changes neither the byte phase nor the data.
- R10: An address load between the two bytes of a pair resets the phase, so the next data byte is taken as a low byte.
- R11: Only the rising edge acts. Holding host_stb high for many clocks counts as one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stb | input | 1 | Host transfer strobe, acts on its rising edge |
| host_ld | input | 1 | 1: transfer loads module/register address |
| host_we | input | 1 | 1: data write, 0: data read |
| host_wdata | input | 8 | Host byte for writes and address loads |
| host_rdata | output | 8 | Byte returned to the host |
| dev_madr | output | 4 | Module address to device |
| dev_radr | output | 4 | Register address to device |
| dev_rd_n | output | 1 | Active-low device read strobe |
| dev_wr_n | output | 1 | Active-low device write strobe |
| dev_en_n | output | 1 | Active-low device enable |
| dev_oe | output | 1 | Bridge drives dev_data when 1 |
| dev_data | inout | 16 | Bidirectional device data |

## Verification
If the byte-phase toggle is wrong, the problem shows at the next data transfer. A write word either comes out with its bytes swapped, or a device write strobe appears after a single byte. On reads, the wrong half of the word is returned, or a device read is missing or extra. A wrong sequencer state shows within one pulse length as a strobe of the wrong width, or as a drive window that does not sit exactly one clock around the write pulse. A strobe that leaks into a busy cycle does not corrupt the current word. It shifts the phase, so the error appears in the following pair.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_WPRE  = 3'd1,
    SQ_WSTB  = 3'd2,
    SQ_WPOST = 3'd3,
    SQ_RSTB  = 3'd4
  } seq_t;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic upper);
    return upper ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/bpb_edge.sv
module bpb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign rise = stb & ~stb_q;

  // R11: a held level never yields two edges in a row
  a_r11_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bpb_phase.sv
module bpb_phase
  import bpb_pkg::*;
#(
  parameter int MA_W = 4,
  parameter int RA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              ld,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [MA_W-1:0]   madr,
  output logic [RA_W-1:0]   radr,
  output logic              phase,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              rd_lo,
  output logic              rd_hi
);
  logic ld_evt, dat_evt;

  assign ld_evt  = evt & ld;
  assign dat_evt = evt & ~ld;
  assign wr_lo   = dat_evt &  we & ~phase;
  assign wr_hi   = dat_evt &  we &  phase;
  assign rd_lo   = dat_evt & ~we & ~phase;
  assign rd_hi   = dat_evt & ~we &  phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      madr  <= '0;
      radr  <= '0;
      phase <= 1'b0;
    end else if (ld_evt) begin
      madr  <= wdata[RA_W +: MA_W];
      radr  <= wdata[RA_W-1:0];
      phase <= 1'b0;
    end else if (dat_evt) begin
      phase <= ~phase;
    end
  end

  a_r10_load_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> !phase);
  a_r3_data_toggles_phase: assert property (@(posedge clk) disable iff (!rst_n)
    dat_evt |=> (phase != $past(phase)));
  a_r2_addr_stable_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_evt |=> ($stable(madr) && $stable(radr)));
endmodule

// File: rtl/bpb_seq.sv
module bpb_seq
  import bpb_pkg::*;
#(
  parameter int WR_PULSE = 3,
  parameter int RD_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WORD_W-1:0] bus_in,
  output logic              busy,
  output logic              wr_n,
  output logic              rd_n,
  output logic              en_n,
  output logic              oe,
  output logic [WORD_W-1:0] bus_out,
  output logic [BYTE_W-1:0] rdata
);
  localparam int MAXP = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
  localparam int CW   = $clog2(MAXP + 1);

  seq_t              state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [WORD_W-1:0] word_q;
  logic              wr_last, rd_last;

  assign wr_last = (cnt == CW'(WR_PULSE - 1));
  assign rd_last = (cnt == CW'(RD_PULSE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      word_q <= '0;
      rdata  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (wr_lo) lo_q <= wdata;
          if (wr_hi) begin
            hi_q  <= wdata;
            state <= SQ_WPRE;
          end
          if (rd_lo) state <= SQ_RSTB;
          if (rd_hi) rdata <= pick_byte(word_q, 1'b1);
        end
        SQ_WPRE: state <= SQ_WSTB;
        SQ_WSTB: begin
          if (wr_last) state <= SQ_WPOST;
          else         cnt   <= cnt + 1'b1;
        end
        SQ_WPOST: state <= SQ_IDLE;
        SQ_RSTB: begin
          if (rd_last) begin
            word_q <= bus_in;
            rdata  <= pick_byte(bus_in, 1'b0);
            state  <= SQ_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state != SQ_IDLE);
  assign oe      = (state == SQ_WPRE) || (state == SQ_WSTB) || (state == SQ_WPOST);
  assign wr_n    = (state != SQ_WSTB);
  assign rd_n    = (state != SQ_RSTB);
  assign en_n    = wr_n & rd_n;
  assign bus_out = join_bytes(hi_q, lo_q);

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  a_r5_drive_covers_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> oe);
  a_r5_drive_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> oe);
  a_r7_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !oe);
  a_r4_high_byte_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (oe && wr_n));
  a_r9_no_event_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wr_lo || wr_hi || rd_lo || rd_hi));
endmodule

// File: rtl/bytepair_bridge.sv
module bytepair_bridge
  import bpb_pkg::*;
#(
  parameter int MA_W     = 4,
  parameter int RA_W     = 4,
  parameter int WR_PULSE = 3,
  parameter int RD_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_stb,
  input  logic              host_ld,
  input  logic              host_we,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic [MA_W-1:0]   dev_madr,
  output logic [RA_W-1:0]   dev_radr,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic              dev_en_n,
  output logic              dev_oe,
  inout  wire  [WORD_W-1:0] dev_data
);
  logic              stb_rise, evt, busy, phase;
  logic              wr_lo, wr_hi, rd_lo, rd_hi;
  logic [WORD_W-1:0] bus_out;

  bpb_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (host_stb),
    .rise (stb_rise)
  );

  assign evt = stb_rise & ~busy;

  bpb_phase #(.MA_W(MA_W), .RA_W(RA_W)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt),
    .ld   (host_ld),
    .we   (host_we),
    .wdata(host_wdata),
    .madr (dev_madr),
    .radr (dev_radr),
    .phase(phase),
    .wr_lo(wr_lo),
    .wr_hi(wr_hi),
    .rd_lo(rd_lo),
    .rd_hi(rd_hi)
  );

  bpb_seq #(.WR_PULSE(WR_PULSE), .RD_PULSE(RD_PULSE)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .rd_lo  (rd_lo),
    .rd_hi  (rd_hi),
    .wdata  (host_wdata),
    .bus_in (dev_data),
    .busy   (busy),
    .wr_n   (dev_wr_n),
    .rd_n   (dev_rd_n),
    .en_n   (dev_en_n),
    .oe     (dev_oe),
    .bus_out(bus_out),
    .rdata  (host_rdata)
  );

  assign dev_data = dev_oe ? bus_out : 'z;

  // R9: a strobe edge seen during a device cycle leaves the phase alone
  a_r9_phase_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stb_rise) |=> $stable(phase));
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dev_oe && dev_wr_n && dev_rd_n));
endmodule

// File: tb/bytepair_bridge_tb.sv
module bytepair_bridge_tb;
  localparam int WRP = 3;
  localparam int RDP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_stb = 1'b0, host_ld = 1'b0, host_we = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [3:0]  dev_madr, dev_radr;
  logic        dev_rd_n, dev_wr_n, dev_en_n, dev_oe;
  wire  [15:0] dev_data;

  int errors = 0, checks = 0;
  int wr_cycles = 0, rd_cycles = 0;
  logic [15:0] exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  bytepair_bridge #(.WR_PULSE(WRP), .RD_PULSE(RDP)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_ld(host_ld),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_madr(dev_madr), .dev_radr(dev_radr), .dev_rd_n(dev_rd_n),
    .dev_wr_n(dev_wr_n), .dev_en_n(dev_en_n), .dev_oe(dev_oe), .dev_data(dev_data)
  );

  function automatic logic [15:0] model_word(input logic [3:0] ma, input logic [3:0] ra);
    return {ma ^ 4'h5, ra, ~ma, ra ^ 4'h9};
  endfunction

  assign dev_data = !dev_rd_n ? model_word(dev_madr, dev_radr) : 16'bz;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: one host transfer, strobe held two clocks
  task automatic host_xfer(input logic ld, input logic we, input logic [7:0] b);
    @(negedge clk);
    host_ld = ld; host_we = we; host_wdata = b; host_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    host_stb = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic write_pair(input logic [7:0] lo, input logic [7:0] hi);
    host_xfer(1'b0, 1'b1, lo);
    exp_q.push_back({hi, lo});
    host_xfer(1'b0, 1'b1, hi);
  endtask

  // monitor / scoreboard
  logic prev_oe = 0, prev2_oe = 0, post_pend = 0;
  int   wr_low = 0, rd_low = 0;
  logic [15:0] cap;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 enable follows strobes", dev_en_n, dev_wr_n & dev_rd_n);
      if (!dev_wr_n) begin
        if (wr_low == 0) begin
          chk("R5 drive one clock before", prev_oe, 1);
          chk("R5 idle two clocks before", prev2_oe, 0);
          cap = dev_data;
        end
        wr_low++;
      end else if (wr_low != 0) begin
        chk("R4 write pulse width", wr_low, WRP);
        chk("R5 drive one clock after", dev_oe, 1);
        if (exp_q.size() == 0) chk("R4 unexpected device write", cap, 16'hxxxx);
        else chk("R4 device write word", cap, exp_q.pop_front());
        wr_cycles++;
        wr_low = 0;
        post_pend = 1;
      end else if (post_pend) begin
        chk("R5 released after write", dev_oe, 0);
        post_pend = 0;
      end
      if (!dev_rd_n) begin
        if (rd_low == 0) chk("R7 released during read", dev_oe, 0);
        rd_low++;
      end else if (rd_low != 0) begin
        chk("R7 read pulse width", rd_low, RDP);
        rd_cycles++;
        rd_low = 0;
      end
    end
    prev2_oe = prev_oe;
    prev_oe = dev_oe;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    int w0, r0;
    logic [15:0] mw;
    repeat (4) @(negedge clk);
    chk("R1 wr_n in reset", dev_wr_n, 1);
    chk("R1 oe in reset", dev_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rd_n after reset", dev_rd_n, 1);
    chk("R1 en_n after reset", dev_en_n, 1);
    chk("R1 rdata after reset", host_rdata, 0);
    chk("R1 address after reset", {dev_madr, dev_radr}, 8'h00);

    host_xfer(1'b1, 1'b0, 8'h3C);
    chk("R2 module address", dev_madr, 4'h3);
    chk("R2 register address", dev_radr, 4'hC);

    w0 = wr_cycles;
    host_xfer(1'b0, 1'b1, 8'h11);
    chk("R3 no write after low byte", wr_cycles, w0);
    chk("R3 bus released after low byte", dev_oe, 0);
    exp_q.push_back(16'h2211);
    host_xfer(1'b0, 1'b1, 8'h22);
    chk("R4 one write after high byte", wr_cycles, w0 + 1);
    write_pair(8'hA5, 8'h5A);
    write_pair(8'h00, 8'hFF);

    mw = model_word(4'h3, 4'hC);
    r0 = rd_cycles;
    host_xfer(1'b0, 1'b0, 8'h00);
    chk("R7 low byte returned", host_rdata, mw[7:0]);
    chk("R7 one device read", rd_cycles, r0 + 1);
    host_xfer(1'b0, 1'b0, 8'h00);
    chk("R8 high byte returned", host_rdata, mw[15:8]);
    chk("R8 no device read", rd_cycles, r0 + 1);

    // R10: address load between halves restarts the pair
    host_xfer(1'b0, 1'b1, 8'h77);
    host_xfer(1'b1, 1'b0, 8'h5A);
    chk("R10 new address", {dev_madr, dev_radr}, 8'h5A);
    write_pair(8'h88, 8'h99);

    // R11: long strobe counts once
    w0 = wr_cycles;
    @(negedge clk);
    host_ld = 0; host_we = 1; host_wdata = 8'h4D; host_stb = 1;
    repeat (20) @(negedge clk);
    host_stb = 0;
    repeat (4) @(negedge clk);
    chk("R11 held strobe no write", wr_cycles, w0);
    exp_q.push_back(16'hB24D);
    host_xfer(1'b0, 1'b1, 8'hB2);
    chk("R11 pair completes", wr_cycles, w0 + 1);

    // R9: strobe during a write cycle is ignored
    host_xfer(1'b0, 1'b1, 8'h01);
    exp_q.push_back(16'h0201);
    @(negedge clk);
    host_wdata = 8'h02; host_stb = 1;
    @(negedge clk);
    host_stb = 0;
    @(negedge clk);
    host_wdata = 8'hEE; host_stb = 1;
    @(negedge clk);
    host_stb = 0;
    repeat (10) @(negedge clk);
    write_pair(8'h33, 8'h44);

    host_xfer(1'b1, 1'b0, 8'hF0);
    mw = model_word(4'hF, 4'h0);
    host_xfer(1'b0, 1'b0, 8'h00);
    chk("R7 low byte second address", host_rdata, mw[7:0]);
    host_xfer(1'b0, 1'b0, 8'h00);
    chk("R8 high byte second address", host_rdata, mw[15:8]);

    repeat (4) @(negedge clk);
    chk("R4 all expected writes seen", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule